// File: doc/BRIEF.md
# Programmable Serial Flash Phase Sequencer

This block drives a single-pad SPI flash by stepping through a short list of phase instructions instead of a fixed command machine. Configuration inputs provide two command slots (each an opcode byte, a bit-cycle count and a chip-select release flag) and two address phase descriptors (cycle count and release flag). They also provide a 32-bit address value and a packed list of instruction codes. A one-cycle start pulse launches the engine. It then walks the list from slot 0, sends each command or address phase MSB first in SPI mode 0, and ends at the first stop code.

A typical use is erasing a sector. Slot 0 sends a write-enable byte with chip-select release. Slot 1 sends the erase opcode with chip select held. The two address phases follow, and the second one releases chip select. A status byte reports idle on bit 4, so software can poll for completion. The serial clock runs at half the system clock.

Top module: `sflashSeq`

## Requirements
- R1: After reset, csN is 1, sck is 0 and seqStatus is 8'h10 (bit 4 = idle, all other bits 0).
- R2: A startReq pulse while idle clears seqStatus bit 4 at the next clock edge and launches a run. A startReq while a run is active has no effect: no extra frames and no restart.
- R3: Instruction codes are 3 bits. Slot k sits at instrList[3k+2:3k]. The codes are 0 = stop, 1 = command slot 0, 2 = command slot 1, 3 = address phase 1, 4 = address phase 2, and 5 to 7 act as stop. Slots run in order from slot 0. A run ends after slot 7 if no stop is found.
- R4: A command phase of c cycles sends the opcode MSB first. For c ≤ 8 it sends the top c bits. For c > 8 it sends all 8 bits followed by zeros. A phase whose cycle count is 0 is skipped without touching csN.
- R5: With a1 and a2 cycles in the two address phases, the low (a1+a2) bits of addrValue go out MSB first. Address phase 1 sends the upper a1 of these bits and address phase 2 sends the rest.
- R6: A phase whose release flag is set raises csN after its last bit. csN then stays high for at least 2 clocks before the next phase. Phases without the flag continue inside the same chip-select frame.
- R7: SPI mode 0 timing applies. sck is 0 whenever csN is 1. Each sck high pulse lasts one clock. mosi never changes while sck is high.
- R8: The stop code raises csN. seqStatus bit 4 rises exactly one clock after the edge on which csN rises, and it is never 1 while csN is 0.
- R9: The erase layout produces two frames. The first is 8'h06. The second is 8'hD8 followed by 24 address bits (a1 = 8) or 32 address bits (a1 = 16).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start pulse, honoured only while idle |
| opcode0 | input | 8 | Command slot 0 opcode |
| opCycles0 | input | 4 | Command slot 0 bit cycles |
| opRelease0 | input | 1 | Command slot 0 chip-select release |
| opcode1 | input | 8 | Command slot 1 opcode |
| opCycles1 | input | 4 | Command slot 1 bit cycles |
| opRelease1 | input | 1 | Command slot 1 chip-select release |
| addrCycles1 | input | 5 | Address phase 1 bit cycles |
| addrRelease1 | input | 1 | Address phase 1 chip-select release |
| addrCycles2 | input | 5 | Address phase 2 bit cycles |
| addrRelease2 | input | 1 | Address phase 2 chip-select release |
| addrValue | input | 32 | Address value |
| instrList | input | 24 | Eight packed 3-bit instruction codes |
| sck | output | 1 | Serial clock, idles low |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| seqStatus | output | 8 | Status byte, bit 4 = idle |

## Verification
The assertions check the wire-level rules on every cycle. These are the mode-0 relation between sck, csN and mosi, the one-clock sck pulse, the minimum chip-select high time, the way the idle bit follows chip-select release, and the clearing of idle on an accepted start. Only the bench scenarios can show frame content. That covers opcode truncation and zero padding, skipped phases, the split of address bits between the two address phases, slot ordering, unknown codes acting as stop, and a run that goes past the last slot. It also covers the start pulse that must be ignored during a run.

// File: rtl/sflashSeqPkg.sv
package sflashSeqPkg;
  localparam int INSTR_W  = 3;
  localparam int STATUS_W = 8;
  localparam int IDLE_BIT = 4;

  localparam logic [INSTR_W-1:0] OP_STOP = 3'd0;
  localparam logic [INSTR_W-1:0] OP_CMD1 = 3'd1;
  localparam logic [INSTR_W-1:0] OP_CMD2 = 3'd2;
  localparam logic [INSTR_W-1:0] OP_ADD1 = 3'd3;
  localparam logic [INSTR_W-1:0] OP_ADD2 = 3'd4;

  // strobes from control to datapath
  typedef struct packed {
    logic initAddr;     // align address into shifter
    logic startPhase;   // drop chip select, put out first bit
    logic phaseIsAddr;  // phase source: address shifter
    logic phaseSlot;    // command slot select
    logic sckRise;
    logic sckFall;
    logic nextBit;      // put out next bit on the falling edge
    logic csHigh;       // release chip select
  } seqStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_LOW, ST_HIGH, ST_GAP, ST_FINISH
  } seqState_t;
endpackage

// File: rtl/sflashSeqCtrl.sv
module sflashSeqCtrl
  import sflashSeqPkg::*;
#(
  parameter int SLOT_COUNT = 8,
  parameter int CMD_CYC_W  = 4,
  parameter int ADDR_CYC_W = 5,
  parameter int GAP_CYCLES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startReq,
  input  logic [CMD_CYC_W-1:0]          opCycles0,
  input  logic                          opRelease0,
  input  logic [CMD_CYC_W-1:0]          opCycles1,
  input  logic                          opRelease1,
  input  logic [ADDR_CYC_W-1:0]         addrCycles1,
  input  logic                          addrRelease1,
  input  logic [ADDR_CYC_W-1:0]         addrCycles2,
  input  logic                          addrRelease2,
  input  logic [SLOT_COUNT*INSTR_W-1:0] instrList,
  output seqStrobe_t                    strobe,
  output logic                          idleFlag
);
  localparam int SLOT_W = $clog2(SLOT_COUNT + 1);
  localparam int CNT_W  = (ADDR_CYC_W > CMD_CYC_W) ? ADDR_CYC_W : CMD_CYC_W;
  localparam int GAP_W  = $clog2(GAP_CYCLES + 1);

  logic [INSTR_W-1:0] slotInstr [SLOT_COUNT];
  for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_unpack
    assign slotInstr[g] = instrList[g*INSTR_W +: INSTR_W];
  end

  seqState_t         state, stateNext;
  logic [SLOT_W-1:0] slot, slotNext;
  logic [CNT_W-1:0]  bitsLeft, bitsNext;
  logic              relLatched, relNext;
  logic [GAP_W-1:0]  gapCnt, gapNext;
  logic              idleNext;

  logic [INSTR_W-1:0] curInstr;
  logic               phaseValid, phaseRelease, phaseIsAddr, phaseSlot;
  logic [CNT_W-1:0]   phaseCycles;

  always_comb begin
    curInstr = OP_STOP;
    for (int i = 0; i < SLOT_COUNT; i++)
      if (slot == SLOT_W'(i)) curInstr = slotInstr[i];
  end

  always_comb begin
    phaseValid   = 1'b1;
    phaseCycles  = '0;
    phaseRelease = 1'b0;
    phaseIsAddr  = 1'b0;
    phaseSlot    = 1'b0;
    case (curInstr)
      OP_CMD1: begin phaseCycles = CNT_W'(opCycles0); phaseRelease = opRelease0; end
      OP_CMD2: begin phaseCycles = CNT_W'(opCycles1); phaseRelease = opRelease1; phaseSlot = 1'b1; end
      OP_ADD1: begin phaseCycles = CNT_W'(addrCycles1); phaseRelease = addrRelease1; phaseIsAddr = 1'b1; end
      OP_ADD2: begin phaseCycles = CNT_W'(addrCycles2); phaseRelease = addrRelease2; phaseIsAddr = 1'b1; end
      default: phaseValid = 1'b0;
    endcase
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    slotNext  = slot;
    bitsNext  = bitsLeft;
    relNext   = relLatched;
    gapNext   = gapCnt;
    idleNext  = idleFlag;
    case (state)
      ST_IDLE: if (startReq) begin
        strobe.initAddr = 1'b1;
        slotNext  = '0;
        idleNext  = 1'b0;
        stateNext = ST_FETCH;
      end
      ST_FETCH: begin
        if (!phaseValid) begin
          strobe.csHigh = 1'b1;
          stateNext     = ST_FINISH;
        end else if (phaseCycles == '0) begin
          slotNext = slot + SLOT_W'(1);
        end else begin
          strobe.startPhase  = 1'b1;
          strobe.phaseIsAddr = phaseIsAddr;
          strobe.phaseSlot   = phaseSlot;
          bitsNext  = phaseCycles;
          relNext   = phaseRelease;
          stateNext = ST_LOW;
        end
      end
      ST_LOW: begin
        strobe.sckRise = 1'b1;
        stateNext      = ST_HIGH;
      end
      ST_HIGH: begin
        strobe.sckFall = 1'b1;
        if (bitsLeft > CNT_W'(1)) begin
          strobe.nextBit = 1'b1;
          bitsNext  = bitsLeft - CNT_W'(1);
          stateNext = ST_LOW;
        end else if (relLatched) begin
          strobe.csHigh = 1'b1;
          gapNext   = '0;
          stateNext = ST_GAP;
        end else begin
          slotNext  = slot + SLOT_W'(1);
          stateNext = ST_FETCH;
        end
      end
      ST_GAP: begin
        if (gapCnt == GAP_W'(GAP_CYCLES - 1)) begin
          slotNext  = slot + SLOT_W'(1);
          stateNext = ST_FETCH;
        end else begin
          gapNext = gapCnt + GAP_W'(1);
        end
      end
      ST_FINISH: begin
        idleNext  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      slot       <= '0;
      bitsLeft   <= '0;
      relLatched <= 1'b0;
      gapCnt     <= '0;
      idleFlag   <= 1'b1;
    end else begin
      state      <= stateNext;
      slot       <= slotNext;
      bitsLeft   <= bitsNext;
      relLatched <= relNext;
      gapCnt     <= gapNext;
      idleFlag   <= idleNext;
    end
  end
endmodule

// File: rtl/sflashSeqData.sv
module sflashSeqData
  import sflashSeqPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ADDR_CYC_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [7:0]            opcode0,
  input  logic [7:0]            opcode1,
  input  logic [ADDR_W-1:0]     addrValue,
  input  logic [ADDR_CYC_W-1:0] addrCycles1,
  input  logic [ADDR_CYC_W-1:0] addrCycles2,
  output logic                  sck,
  output logic                  csN,
  output logic                  mosi
);
  localparam int TOT_W = ADDR_CYC_W + 1;
  localparam int SH_W  = $clog2(ADDR_W) + 1;

  logic [TOT_W-1:0]  totalCycles;
  logic [SH_W-1:0]   alignShift;
  logic [ADDR_W-1:0] alignedAddr;
  logic [7:0]        opcSel;

  logic [ADDR_W-1:0] addrShift;
  logic [7:0]        cmdShift;
  logic              useAddr;

  always_comb begin
    totalCycles = TOT_W'(addrCycles1) + TOT_W'(addrCycles2);
    if (int'(totalCycles) >= ADDR_W) alignShift = '0;
    else                             alignShift = SH_W'(ADDR_W - int'(totalCycles));
    alignedAddr = addrValue << alignShift;
    opcSel      = strobe.phaseSlot ? opcode1 : opcode0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sck       <= 1'b0;
      csN       <= 1'b1;
      mosi      <= 1'b0;
      addrShift <= '0;
      cmdShift  <= '0;
      useAddr   <= 1'b0;
    end else begin
      if (strobe.initAddr) addrShift <= alignedAddr;
      if (strobe.startPhase) begin
        csN     <= 1'b0;
        useAddr <= strobe.phaseIsAddr;
        if (strobe.phaseIsAddr) begin
          mosi      <= addrShift[ADDR_W-1];
          addrShift <= {addrShift[ADDR_W-2:0], 1'b0};
        end else begin
          mosi     <= opcSel[7];
          cmdShift <= {opcSel[6:0], 1'b0};
        end
      end
      if (strobe.sckRise) sck <= 1'b1;
      if (strobe.sckFall) sck <= 1'b0;
      if (strobe.nextBit) begin
        if (useAddr) begin
          mosi      <= addrShift[ADDR_W-1];
          addrShift <= {addrShift[ADDR_W-2:0], 1'b0};
        end else begin
          mosi     <= cmdShift[7];
          cmdShift <= {cmdShift[6:0], 1'b0};
        end
      end
      if (strobe.csHigh) csN <= 1'b1;
    end
  end
endmodule

// File: rtl/sflashSeq.sv
module sflashSeq
  import sflashSeqPkg::*;
#(
  parameter int SLOT_COUNT = 8,
  parameter int ADDR_W     = 32,
  parameter int CMD_CYC_W  = 4,
  parameter int ADDR_CYC_W = 5,
  parameter int GAP_CYCLES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startReq,
  input  logic [7:0]                    opcode0,
  input  logic [CMD_CYC_W-1:0]          opCycles0,
  input  logic                          opRelease0,
  input  logic [7:0]                    opcode1,
  input  logic [CMD_CYC_W-1:0]          opCycles1,
  input  logic                          opRelease1,
  input  logic [ADDR_CYC_W-1:0]         addrCycles1,
  input  logic                          addrRelease1,
  input  logic [ADDR_CYC_W-1:0]         addrCycles2,
  input  logic                          addrRelease2,
  input  logic [ADDR_W-1:0]             addrValue,
  input  logic [SLOT_COUNT*INSTR_W-1:0] instrList,
  output logic                          sck,
  output logic                          csN,
  output logic                          mosi,
  output logic [STATUS_W-1:0]           seqStatus
);
  seqStrobe_t strobe;
  logic       idleFlag;

  sflashSeqCtrl #(
    .SLOT_COUNT(SLOT_COUNT), .CMD_CYC_W(CMD_CYC_W),
    .ADDR_CYC_W(ADDR_CYC_W), .GAP_CYCLES(GAP_CYCLES)
  ) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .opCycles0(opCycles0), .opRelease0(opRelease0),
    .opCycles1(opCycles1), .opRelease1(opRelease1),
    .addrCycles1(addrCycles1), .addrRelease1(addrRelease1),
    .addrCycles2(addrCycles2), .addrRelease2(addrRelease2),
    .instrList(instrList), .strobe(strobe), .idleFlag(idleFlag)
  );

  sflashSeqData #(.ADDR_W(ADDR_W), .ADDR_CYC_W(ADDR_CYC_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opcode0(opcode0), .opcode1(opcode1), .addrValue(addrValue),
    .addrCycles1(addrCycles1), .addrCycles2(addrCycles2),
    .sck(sck), .csN(csN), .mosi(mosi)
  );

  always_comb begin
    seqStatus           = '0;
    seqStatus[IDLE_BIT] = idleFlag;
  end
endmodule

// File: rtl/sflashSeqChecker.sv
module sflashSeqChecker (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       sck,
  input logic       csN,
  input logic       mosi,
  input logic [7:0] seqStatus
);
  p_sck_low_when_deselected_r7: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_mosi_still_while_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> $stable(mosi));

  p_sck_one_clock_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |=> $fell(sck));

  p_cs_min_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |=> csN ##1 csN);

  p_idle_implies_deselect_r8: assert property (@(posedge clk) disable iff (!rstN)
    seqStatus[4] |-> csN);

  p_idle_follows_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqStatus[4]) |-> $past(csN));

  p_start_clears_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (seqStatus[4] && startReq) |=> !seqStatus[4]);
endmodule

bind sflashSeq sflashSeqChecker chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .sck(sck),
  .csN(csN), .mosi(mosi), .seqStatus(seqStatus)
);

// File: tb/sflashSeq_test.sv
`timescale 1ns/1ps
module sflashSeq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  opcode0 = 8'h06, opcode1 = 8'hD8;
  logic [3:0]  opCycles0 = 4'd8, opCycles1 = 4'd8;
  logic        opRelease0 = 1'b1, opRelease1 = 1'b0;
  logic [4:0]  addrCycles1 = 5'd8, addrCycles2 = 5'd16;
  logic        addrRelease1 = 1'b0, addrRelease2 = 1'b1;
  logic [31:0] addrValue = '0;
  logic [23:0] instrList = '0;
  logic        sck, csN, mosi;
  logic [7:0]  seqStatus;

  sflashSeq uut (.*);

  always #4 clk = ~clk;

  int nChecks = 0, nErr = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus monitor
  int          armCnt = 0, seenArm = 0, cyc = 0;
  logic        prevSck = 0, prevCsN = 1, prevIdle = 1, prevMosi = 0;
  logic [63:0] curBits = '0;
  int          curLen = 0;
  logic [63:0] frBits [8];
  int          frLen [8];
  int          frCnt = 0, minGap = 1000, gapRun = 0;
  int          csRiseCyc = -1, idleRiseCyc = -1, modeErr = 0;

  always @(negedge clk) begin
    cyc++;
    if (armCnt != seenArm) begin
      seenArm = armCnt; frCnt = 0; curLen = 0; curBits = '0;
      minGap = 1000; gapRun = 0; csRiseCyc = -1; idleRiseCyc = -1;
    end
    if (rstN) begin
      if (sck && mosi !== prevMosi) modeErr++;
      if (sck && prevSck) modeErr++;
      if (sck && csN) modeErr++;
    end
    if (!csN) begin
      if (sck && !prevSck) begin curBits = {curBits[62:0], mosi}; curLen++; end
      if (prevCsN && frCnt > 0 && gapRun < minGap) minGap = gapRun;
    end
    if (csN && !prevCsN) begin
      if (frCnt < 8) begin frBits[frCnt] = curBits; frLen[frCnt] = curLen; end
      frCnt++; curBits = '0; curLen = 0; csRiseCyc = cyc; gapRun = 0;
    end
    if (csN) gapRun++;
    if (seqStatus[4] && !prevIdle) idleRiseCyc = cyc;
    prevSck = sck; prevCsN = csN; prevIdle = seqStatus[4]; prevMosi = mosi;
  end

  function automatic logic [23:0] pack8(input logic [2:0] s0, s1, s2, s3, s4, s5, s6, s7);
    return {s7, s6, s5, s4, s3, s2, s1, s0};
  endfunction

  function automatic logic [63:0] cmdExp(input logic [7:0] opc, input int c);
    if (c <= 8) return 64'(opc) >> (8 - c);
    return 64'(opc) << (c - 8);
  endfunction

  task automatic launch();
    @(negedge clk); #1;
    armCnt++; startReq = 1'b1;
    @(negedge clk);
    chk("R2 idle clears on start", 64'(seqStatus), 64'h00);
    #1 startReq = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (seqStatus[4]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic setErase(input int a1, input logic [31:0] addr);
    opcode0 = 8'h06; opCycles0 = 4'd8; opRelease0 = 1'b1;
    opcode1 = 8'hD8; opCycles1 = 4'd8; opRelease1 = 1'b0;
    addrCycles1 = 5'(a1); addrRelease1 = 1'b0;
    addrCycles2 = 5'd16;  addrRelease2 = 1'b1;
    addrValue = addr;
    instrList = pack8(3'd1, 3'd2, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 csN", 64'(csN), 64'd1);
    chk("R1 sck", 64'(sck), 64'd0);
    chk("R1 status", 64'(seqStatus), 64'h10);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 status after release", 64'(seqStatus), 64'h10);

    // R9 R5 R6: erase sweep over both address modes and walking addresses
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 64; b++) begin
        int a1 = (m == 0) ? 8 : 16;
        int n = a1 + 16;
        logic [31:0] addr = (b < 32) ? (32'd1 << b) : ~(32'd1 << (b - 32)) ^ 32'h5A00_00A5;
        logic [63:0] mask = (64'd1 << n) - 64'd1;
        setErase(a1, addr);
        launch();
        waitIdle();
        chk("R9 frame count", 64'(frCnt), 64'd2);
        chk("R9 write-enable frame", frBits[0], 64'h06);
        chk("R9 write-enable length", 64'(frLen[0]), 64'd8);
        chk("R5 erase frame bits", frBits[1], (64'hD8 << n) | (64'(addr) & mask));
        chk("R5 erase frame length", 64'(frLen[1]), 64'(8 + n));
        chk("R6 min chip-select gap", 64'(minGap >= 2), 64'd1);
      end
    end

    // R6 R8: chained phases without release, idle one clock after final release
    setErase(8, 32'hCAFE_1234);
    opRelease0 = 1'b0; addrCycles2 = 5'd8; addrRelease2 = 1'b0;
    instrList = pack8(3'd1, 3'd3, 3'd4, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
    launch();
    waitIdle();
    chk("R6 single frame", 64'(frCnt), 64'd1);
    chk("R5 chained bits", frBits[0], {40'h0, 8'h06, 16'h1234});
    chk("R8 idle one clock after release", 64'(idleRiseCyc - csRiseCyc), 64'd1);

    // R4: command cycle sweep 0..15, zero cycles skipped
    for (int c = 0; c < 16; c++) begin
      opcode0 = 8'hB7; opCycles0 = 4'(c); opRelease0 = 1'b1;
      instrList = pack8(3'd1, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0);
      launch();
      waitIdle();
      chk("R4 frame count", 64'(frCnt), (c == 0) ? 64'd0 : 64'd1);
      if (c != 0) begin
        chk("R4 truncated/padded opcode", frBits[0], cmdExp(8'hB7, c));
        chk("R4 length", 64'(frLen[0]), 64'(c));
      end
    end

    // R3: order from slot 0, slot 1 opcode first
    opcode0 = 8'h3C; opCycles0 = 4'd8; opRelease0 = 1'b1;
    opcode1 = 8'hC5; opCycles1 = 4'd8; opRelease1 = 1'b1;
    instrList = pack8(3'd2, 3'd1, 3'd0, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1);
    launch();
    waitIdle();
    chk("R3 stop ends list", 64'(frCnt), 64'd2);
    chk("R3 first slot", frBits[0], 64'hC5);
    chk("R3 second slot", frBits[1], 64'h3C);

    // R3: codes 5..7 act as stop
    for (int u = 5; u < 8; u++) begin
      instrList = pack8(3'd1, 3'(u), 3'd2, 3'd2, 3'd0, 3'd0, 3'd0, 3'd0);
      launch();
      waitIdle();
      chk("R3 unknown code stops", 64'(frCnt), 64'd1);
    end

    // R3: no stop in list, runs all eight slots
    instrList = pack8(3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2, 3'd1);
    launch();
    waitIdle();
    chk("R3 list exhaustion", 64'(frCnt), 64'd8);
    chk("R3 last slot content", frBits[7], 64'h3C);
    chk("R8 idle after exhaustion", 64'(seqStatus), 64'h10);

    // R2: start during a run is ignored
    setErase(16, 32'h89AB_CDEF);
    launch();
    repeat (20) @(negedge clk);
    #1 startReq = 1'b1;
    @(negedge clk); #1 startReq = 1'b0;
    waitIdle();
    repeat (60) @(negedge clk);
    chk("R2 busy start ignored frames", 64'(frCnt), 64'd2);
    chk("R2 busy start ignored status", 64'(seqStatus), 64'h10);
    chk("R2 busy start ignored csN", 64'(csN), 64'd1);

    // R7: mode 0 relation observed across all runs
    chk("R7 mode-0 violations", 64'(modeErr), 64'd0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule